// File: doc/BRIEF.md
# Double-Precision Rounding Outcome Selector

This block sits at the back end of a double-precision arithmetic datapath. The upstream stages deliver three things: a sign, a truncated magnitude that is already normalized, and a classification of that magnitude. The classification says whether the value has overflowed past the largest finite number, or has shrunk to a nonzero value below the smallest subnormal. Otherwise the value is finite and carries a guard (half-ulp) bit and a sticky bit. The block applies one of four rounding modes and produces the final signed 64-bit word. It also raises the overflow, underflow and inexact flags.

Each operation is presented with a valid strobe and comes out one cycle later. For overflow and total underflow, the block picks the saturated or infinite value, or the zero or smallest-subnormal value. The choice depends on the mode and on the direction in which that mode rounds a value of the given sign. For finite values it decides whether to add one ulp to the magnitude. A carry out of the fraction moves into the exponent. An increment that reaches the all-ones exponent becomes infinity and is reported as overflow.

Top module: `fp_round_sel`

## Requirements
- R1: The result and flags register one cycle after a cycle with `valid_i` high, and `valid_o` is high in exactly that following cycle. While `valid_i` is low, the result and flags hold their values. After reset all outputs are zero.
- R2: Mode encoding is 0 nearest-even, 1 toward zero, 2 toward plus infinity, 3 toward minus infinity. On `ovf_i`, the magnitude is infinity (0x7FF0000000000000) in mode 0, in mode 2 for a positive sign and in mode 3 for a negative sign. In all other cases it is the largest finite magnitude (0x7FEFFFFFFFFFFFFF). Bit 63 of the result always equals `sign_i`.
- R3: An overflow outcome raises `ovf_o` and `inx_o` and leaves `unf_o` low, in every mode.
- R4: On `tiny_i`, the magnitude is 1 (smallest subnormal) in mode 2 for a positive sign and in mode 3 for a negative sign. In all other cases it is zero. `unf_o` and `inx_o` are raised and `ovf_o` stays low.
- R5: When `ovf_i` and `tiny_i` are both set, the overflow outcome is taken.
- R6: For a finite value, mode 1 never increments. Mode 2 increments the magnitude by one when the sign is positive and guard or sticky is set. Mode 3 does the same when the sign is negative.
- R7: In mode 0, the magnitude is incremented when guard is set and either sticky or the magnitude's LSB is set. A tie with LSB 0 keeps the truncated value.
- R8: For a finite value, `inx_o` equals guard OR sticky and `unf_o` is low. An exact value (guard and sticky clear) raises no flag and returns the truncated magnitude.
- R9: An increment with an all-ones fraction clears the fraction and adds one to the exponent field (bits 62:52).
- R10: An increment that makes the exponent all ones yields infinity with `ovf_o` and `inx_o` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| mode_i | input | 2 | Rounding mode |
| sign_i | input | 1 | Sign of the value |
| ovf_i | input | 1 | Value exceeds the largest finite magnitude |
| tiny_i | input | 1 | Value nonzero but below the smallest subnormal |
| trunc_mag_i | input | 63 | Truncated magnitude: exponent 62:52, fraction 51:0; exponent never all ones |
| guard_i | input | 1 | Half-ulp bit below the LSB |
| sticky_i | input | 1 | OR of all bits below guard |
| valid_o | output | 1 | Result valid |
| result_o | output | 64 | Final signed double-precision word |
| ovf_o | output | 1 | Overflow flag |
| unf_o | output | 1 | Underflow flag |
| inx_o | output | 1 | Inexact flag |

## Verification
Two functions can land in the same cycle: the rounding increment and overflow detection. A finite magnitude sitting at the largest finite value may have to round up. The bench provokes this directly by presenting that magnitude with guard set in mode 0 and in the matching directed mode. It then expects infinity with both overflow and inexact, and expects only inexact when the same stimulus is given in the opposite direction. A second overlap is both classification inputs asserted at once. The bench expects the overflow outcome and never the underflow flag. The random stream also reaches these cases, because it draws exponents near the top of the range.

// File: rtl/fp_round_pkg.sv
package fp_round_pkg;
  localparam int EXP_W  = 11;
  localparam int MAN_W  = 52;
  localparam int MAG_W  = EXP_W + MAN_W;
  localparam int WORD_W = MAG_W + 1;

  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'd0,
    RM_ZERO      = 2'd1,
    RM_UP        = 2'd2,
    RM_DOWN      = 2'd3
  } rmode_e;

  typedef struct packed {
    logic ovf;
    logic unf;
    logic inx;
  } flags_t;
endpackage

// File: rtl/fp_dir_decode.sv
module fp_dir_decode
  import fp_round_pkg::*;
(
  input  rmode_e mode_i,
  input  logic   sign_i,
  input  logic   guard_i,
  input  logic   sticky_i,
  input  logic   lsb_i,
  output logic   sat_away_o,
  output logic   dir_away_o,
  output logic   inc_o,
  output logic   inexact_o
);
  always_comb begin
    inexact_o  = guard_i | sticky_i;
    // directed modes round away only when their direction matches the sign
    dir_away_o = ((mode_i == RM_UP) && !sign_i) || ((mode_i == RM_DOWN) && sign_i);
    sat_away_o = (mode_i == RM_NEAR_EVEN) || dir_away_o;
    unique case (mode_i)
      RM_NEAR_EVEN: inc_o = guard_i & (sticky_i | lsb_i);
      RM_ZERO:      inc_o = 1'b0;
      RM_UP:        inc_o = ~sign_i & inexact_o;
      RM_DOWN:      inc_o = sign_i & inexact_o;
      default:      inc_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fp_mag_incr.sv
module fp_mag_incr #(
  parameter int EXP_W = fp_round_pkg::EXP_W,
  parameter int MAN_W = fp_round_pkg::MAN_W,
  localparam int MAG_W = EXP_W + MAN_W
) (
  input  logic [MAG_W-1:0] mag_i,
  input  logic             inc_i,
  output logic [MAG_W-1:0] mag_o,
  output logic             ovf_o
);
  // full-width add: fraction carry ripples straight into the exponent
  assign mag_o = mag_i + MAG_W'(inc_i);
  assign ovf_o = &mag_o[MAG_W-1:MAN_W];
endmodule

// File: rtl/fp_special_sel.sv
module fp_special_sel
  import fp_round_pkg::*;
#(
  parameter int EXP_W = fp_round_pkg::EXP_W,
  parameter int MAN_W = fp_round_pkg::MAN_W,
  localparam int MAG_W = EXP_W + MAN_W
) (
  input  logic             ovf_i,
  input  logic             tiny_i,
  input  logic             sat_away_i,
  input  logic             dir_away_i,
  input  logic [MAG_W-1:0] rnd_mag_i,
  input  logic             rnd_ovf_i,
  input  logic             inexact_i,
  output logic [MAG_W-1:0] mag_o,
  output flags_t           flags_o
);
  localparam logic [MAG_W-1:0] INF_MAG  = {{EXP_W{1'b1}}, {MAN_W{1'b0}}};
  localparam logic [MAG_W-1:0] MAXF_MAG = {{(EXP_W-1){1'b1}}, 1'b0, {MAN_W{1'b1}}};
  localparam logic [MAG_W-1:0] MINS_MAG = MAG_W'(1);

  always_comb begin
    mag_o   = rnd_mag_i;
    flags_o = '{ovf: 1'b0, unf: 1'b0, inx: inexact_i};
    if (ovf_i) begin
      mag_o   = sat_away_i ? INF_MAG : MAXF_MAG;
      flags_o = '{ovf: 1'b1, unf: 1'b0, inx: 1'b1};
    end else if (tiny_i) begin
      mag_o   = dir_away_i ? MINS_MAG : '0;
      flags_o = '{ovf: 1'b0, unf: 1'b1, inx: 1'b1};
    end else if (rnd_ovf_i) begin
      flags_o = '{ovf: 1'b1, unf: 1'b0, inx: 1'b1};
    end
  end
endmodule

// File: rtl/fp_round_sel.sv
module fp_round_sel
  import fp_round_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [1:0]         mode_i,
  input  logic               sign_i,
  input  logic               ovf_i,
  input  logic               tiny_i,
  input  logic [MAG_W-1:0]   trunc_mag_i,
  input  logic               guard_i,
  input  logic               sticky_i,
  output logic               valid_o,
  output logic [WORD_W-1:0]  result_o,
  output logic               ovf_o,
  output logic               unf_o,
  output logic               inx_o
);
  logic             sat_away, dir_away, inc, inexact, rnd_ovf;
  logic [MAG_W-1:0] rnd_mag, fin_mag;
  flags_t           fin_flags;

  fp_dir_decode u_dir (
    .mode_i     (rmode_e'(mode_i)),
    .sign_i     (sign_i),
    .guard_i    (guard_i),
    .sticky_i   (sticky_i),
    .lsb_i      (trunc_mag_i[0]),
    .sat_away_o (sat_away),
    .dir_away_o (dir_away),
    .inc_o      (inc),
    .inexact_o  (inexact)
  );

  fp_mag_incr #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_incr (
    .mag_i (trunc_mag_i),
    .inc_i (inc),
    .mag_o (rnd_mag),
    .ovf_o (rnd_ovf)
  );

  fp_special_sel #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_sel (
    .ovf_i      (ovf_i),
    .tiny_i     (tiny_i),
    .sat_away_i (sat_away),
    .dir_away_i (dir_away),
    .rnd_mag_i  (rnd_mag),
    .rnd_ovf_i  (rnd_ovf),
    .inexact_i  (inexact),
    .mag_o      (fin_mag),
    .flags_o    (fin_flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      ovf_o    <= 1'b0;
      unf_o    <= 1'b0;
      inx_o    <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= {sign_i, fin_mag};
        ovf_o    <= fin_flags.ovf;
        unf_o    <= fin_flags.unf;
        inx_o    <= fin_flags.inx;
      end
    end
  end
endmodule

// File: rtl/fp_round_sel_chk.sv
module fp_round_sel_chk
  import fp_round_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              sign_i,
  input logic              ovf_i,
  input logic              tiny_i,
  input logic              guard_i,
  input logic              sticky_i,
  input logic              valid_o,
  input logic [WORD_W-1:0] result_o,
  input logic              ovf_o,
  input logic              unf_o,
  input logic              inx_o
);
  // R1
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R1
  hold_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o) && $stable({ovf_o, unf_o, inx_o}));
  // R2
  sign_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> result_o[WORD_W-1] == $past(sign_i));
  // R3
  ovf_inexact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> inx_o && !unf_o);
  // R4
  unf_inexact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |-> inx_o && !ovf_o);
  // R5
  ovf_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ovf_i && tiny_i |=> ovf_o && !unf_o);
  // R8
  exact_no_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !ovf_i && !tiny_i && !guard_i && !sticky_i |=> !inx_o && !ovf_o && !unf_o);
endmodule

bind fp_round_sel fp_round_sel_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .sign_i   (sign_i),
  .ovf_i    (ovf_i),
  .tiny_i   (tiny_i),
  .guard_i  (guard_i),
  .sticky_i (sticky_i),
  .valid_o  (valid_o),
  .result_o (result_o),
  .ovf_o    (ovf_o),
  .unf_o    (unf_o),
  .inx_o    (inx_o)
);

// File: tb/tb_fp_round_sel.sv
module tb_fp_round_sel;
  localparam logic [62:0] INF_M  = 63'h7FF0_0000_0000_0000;
  localparam logic [62:0] MAXF_M = 63'h7FEF_FFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [1:0]  mode = '0;
  logic        sign = 1'b0, ovf = 1'b0, tiny = 1'b0, guard = 1'b0, sticky = 1'b0;
  logic [62:0] trunc = '0;
  logic        valid_q, ovf_q, unf_q, inx_q;
  logic [63:0] result_q;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  fp_round_sel dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .mode_i(mode), .sign_i(sign),
    .ovf_i(ovf), .tiny_i(tiny), .trunc_mag_i(trunc), .guard_i(guard), .sticky_i(sticky),
    .valid_o(valid_q), .result_o(result_q), .ovf_o(ovf_q), .unf_o(unf_q), .inx_o(inx_q)
  );

  // returns {ovf, unf, inx, result}
  function automatic logic [66:0] model(logic [1:0] m, logic s, logic o, logic t,
                                        logic [62:0] tr, logic g, logic st);
    logic toward = (m == 2'd2 && !s) || (m == 2'd3 && s);
    logic up;
    logic [62:0] v;
    if (o) return {3'b101, s, (m == 2'd0 || toward) ? INF_M : MAXF_M};
    if (t) return {3'b011, s, toward ? 63'd1 : 63'd0};
    if (m == 2'd0)      up = g && (st || tr[0]);
    else if (m == 2'd1) up = 1'b0;
    else                up = toward && (g || st);
    v = tr + {62'd0, up};
    if (v[62:52] == 11'h7FF) return {3'b101, s, v};
    return {2'b00, g | st, s, v};
  endfunction

  task automatic check(string tag, logic [66:0] exp);
    checks++;
    if ({ovf_q, unf_q, inx_q, result_q} !== exp || valid_q !== 1'b1) begin
      errors++;
      $display("FAIL %s: got v=%b o/u/i=%b%b%b res=%h, exp o/u/i=%b res=%h",
               tag, valid_q, ovf_q, unf_q, inx_q, result_q, exp[66:64], exp[63:0]);
    end
  endtask

  task automatic run(string tag, logic [1:0] m, logic s, logic o, logic t,
                     logic [62:0] tr, logic g, logic st);
    @(negedge clk);
    valid = 1'b1; mode = m; sign = s; ovf = o; tiny = t; trunc = tr; guard = g; sticky = st;
    @(negedge clk);
    valid = 1'b0;
    check(tag, model(m, s, o, t, tr, g, st));
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [66:0] held;
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    checks++;
    if ({valid_q, ovf_q, unf_q, inx_q, result_q} !== '0) begin
      errors++;
      $display("FAIL R1 reset: got %h exp 0", {valid_q, ovf_q, unf_q, inx_q, result_q});
    end
    rst_n = 1'b1;

    for (int m = 0; m < 4; m++) begin
      run("R2 R3 ovf pos", 2'(m), 1'b0, 1'b1, 1'b0, 63'h1234, 1'b0, 1'b0);
      run("R2 R3 ovf neg", 2'(m), 1'b1, 1'b1, 1'b0, 63'h1234, 1'b1, 1'b0);
      run("R4 tiny pos", 2'(m), 1'b0, 1'b0, 1'b1, 63'h0, 1'b0, 1'b1);
      run("R4 tiny neg", 2'(m), 1'b1, 1'b0, 1'b1, 63'h0, 1'b0, 1'b1);
      run("R6 below half pos", 2'(m), 1'b0, 1'b0, 1'b0, 63'h3FF0_0000_0000_0010, 1'b0, 1'b1);
      run("R6 below half neg", 2'(m), 1'b1, 1'b0, 1'b0, 63'h3FF0_0000_0000_0010, 1'b0, 1'b1);
      run("R8 exact", 2'(m), 1'b1, 1'b0, 1'b0, 63'h4000_0000_0000_0003, 1'b0, 1'b0);
      run("R10 max round", 2'(m), 1'b0, 1'b0, 1'b0, MAXF_M, 1'b1, 1'b0);
      run("R10 max round neg", 2'(m), 1'b1, 1'b0, 1'b0, MAXF_M, 1'b1, 1'b1);
    end
    run("R5 both set", 2'd1, 1'b0, 1'b1, 1'b1, 63'h0, 1'b0, 1'b0);
    run("R5 both set up", 2'd2, 1'b0, 1'b1, 1'b1, 63'h0, 1'b0, 1'b0);
    run("R7 tie even", 2'd0, 1'b0, 1'b0, 1'b0, 63'h3FF0_0000_0000_0002, 1'b1, 1'b0);
    run("R7 tie odd", 2'd0, 1'b0, 1'b0, 1'b0, 63'h3FF0_0000_0000_0003, 1'b1, 1'b0);
    run("R7 above half", 2'd0, 1'b1, 1'b0, 1'b0, 63'h3FF0_0000_0000_0002, 1'b1, 1'b1);
    run("R9 carry", 2'd2, 1'b0, 1'b0, 1'b0, 63'h3FFF_FFFF_FFFF_FFFF, 1'b1, 1'b0);
    run("R9 carry near", 2'd0, 1'b1, 1'b0, 1'b0, 63'h000F_FFFF_FFFF_FFFF, 1'b1, 1'b1);

    // R1 hold: idle cycle keeps the last result
    held = {ovf_q, unf_q, inx_q, result_q};
    @(negedge clk);
    checks++;
    if (valid_q !== 1'b0 || {ovf_q, unf_q, inx_q, result_q} !== held) begin
      errors++;
      $display("FAIL R1 hold: got v=%b %h exp v=0 %h", valid_q,
               {ovf_q, unf_q, inx_q, result_q}, held);
    end

    for (int i = 0; i < 3000; i++) begin
      logic [1:0]  m = 2'($urandom_range(3));
      logic        s = 1'($urandom);
      logic        o = ($urandom_range(15) == 0);
      logic        t = ($urandom_range(15) == 0);
      logic [62:0] tr = {$urandom, $urandom}[62:0];
      if ($urandom_range(3) == 0) tr[62:52] = 11'h7FE;
      if ($urandom_range(3) == 0) tr[51:0] = '1;
      if (tr[62:52] == 11'h7FF) tr[62:52] = 11'h7FE;
      if (o)      run("R2 rand", m, s, o, t, tr, 1'($urandom), 1'($urandom));
      else if (t) run("R4 rand", m, s, o, t, tr, 1'($urandom), 1'($urandom));
      else        run("R6 rand", m, s, o, t, tr, 1'($urandom), 1'($urandom));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule